// File: doc/BRIEF.md
# Serial EEPROM Burst Read Sequencer

This block is a host-side master for a three-wire-plus-select serial EEPROM (Microwire style: chip select, serial clock, data toward the memory, data from the memory). A single start pulse with a start address and a word count makes it fetch that many consecutive 16-bit words. Every word gets its own short read frame. The frame opens with select raised for one idle clock period. The sequencer then sends the start bit and the read opcode, and after that the address with its MSB first. It clocks in seventeen bits and drops the leading dummy zero. Select then goes low for one clock period before the next address is used.

The serial clock is built from the system clock. Each low and high phase lasts a set number of system cycles. When the ready handshake is turned on, a phase can also be held until `rdy_i` rises, up to a bounded number of extra cycles. Each captured word is presented with its address and a one-cycle strobe. The end of the whole run is marked by a one-cycle done pulse.

Top module: `eeprom_burst_reader`

## Requirements
- R1: While the block is idle, a `start_i` pulse with a nonzero `count_i` raises `busy_o` in the next cycle. A `start_i` pulse while `busy_o` is high is ignored: it changes neither the words produced nor the number of done pulses.
- R2: A start with `count_i` of zero pulses `done_o` high in the next cycle and produces no word. `busy_o` stays low.
- R3: Each frame opens with `cs_o` rising while `sk_o` is low. One full `sk_o` period with `do_o` low follows before the first 1 bit.
- R4: After the opening period, `do_o` carries 1, 1, 0 (the start bit, then read opcode 10). Then come the ADDR_W address bits, MSB first. `do_o` changes only while `sk_o` is low.
- R5: After the address, seventeen `sk_o` periods follow. `di_i` is sampled at the end of each low phase. The first sample is discarded, and the next sixteen form the word with its MSB first.
- R6: `valid_o` is high for one cycle per word, with `word_o` and `addr_o` holding the word and its address. This happens while `sk_o` is high during the last read period.
- R7: After each word, `cs_o` is low for exactly one full `sk_o` period before the next frame. While the block is idle, `sk_o`, `cs_o` and `do_o` are low.
- R8: The address starts at `start_addr_i` and increments by one per word, modulo 2^ADDR_W, for `count_i` words.
- R9: `done_o` is high for one cycle, in the cycle where `busy_o` returns low after the last word.
- R10: With ready high (or the handshake turned off), every low phase lasts exactly T_LOW cycles and every high phase exactly T_HIGH cycles. A run of N words therefore keeps `busy_o` high for N·(ADDR_W+22)·(T_LOW+T_HIGH) cycles.
- R11: With USE_RDY=1, a phase does not end before its minimum length. It extends until `rdy_i` is high, by at most RDY_TMO extra cycles. With `rdy_i` held low, each phase lasts its minimum plus RDY_TMO cycles.
- R12: After reset, `busy_o`, `valid_o`, `done_o`, `sk_o`, `cs_o` and `do_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| start_addr_i | input | ADDR_W | First word address |
| count_i | input | ADDR_W+1 | Number of words to read |
| rdy_i | input | 1 | Phase ready handshake |
| di_i | input | 1 | Serial data from the EEPROM |
| sk_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| do_o | output | 1 | Serial data to the EEPROM |
| word_o | output | 16 | Captured word |
| addr_o | output | ADDR_W | Address of the captured word |
| valid_o | output | 1 | Word strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete pulse |

## Verification
Some properties are checked on every cycle. The lower bound on each clock phase and the upper bound set by the timeout are checked this way. So are a quiet bus while idle, `do_o` staying put while the clock is high, select rising only in the low phase, and the strobe and done pulse shapes. The bench scenarios cover the rest: that the right words arrive from a memory model at the right incrementing addresses, including wrap-around; that the opcode and the opening and closing periods look correct as seen from the memory; that total run lengths match with ready high and with ready stuck low; that a zero count behaves as specified; and that a start while busy is ignored.

// File: rtl/eerd_pkg.sv
package eerd_pkg;
  localparam int DATA_W    = 16;
  localparam int READ_BITS = DATA_W + 1;   // dummy zero plus data
  localparam int BC_W      = 5;
  localparam logic [2:0] CMD_READ = 3'b110; // start bit, opcode 10

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD,
    ST_ADDR,
    ST_READ,
    ST_CLOSE
  } eerd_state_e;
endpackage

// File: rtl/eerd_phase_timer.sv
module eerd_phase_timer #(
  parameter int T_HIGH  = 75,
  parameter int T_LOW   = 25,
  parameter bit USE_RDY = 1'b1,
  parameter int RDY_TMO = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic hi_i,
  input  logic rdy_i,
  output logic done_o
);
  localparam int T_MAX = (T_HIGH > T_LOW) ? T_HIGH : T_LOW;
  localparam int TW    = $clog2(T_MAX + 1) + 1;
  localparam int WW    = $clog2(RDY_TMO + 1);

  logic          active_q, hi_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;
  logic          min_ok, wait_ok;

  assign lim    = hi_q ? TW'(T_HIGH) : TW'(T_LOW);
  assign min_ok = cnt_q >= lim;
  assign done_o = active_q && min_ok && wait_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_q     <= 1'b0;
      cnt_q    <= '0;
    end else if (kick_i) begin
      active_q <= 1'b1;
      hi_q     <= hi_i;
      cnt_q    <= TW'(1);
    end else begin
      if (done_o) active_q <= 1'b0;
      if (active_q && !min_ok) cnt_q <= cnt_q + TW'(1);
    end
  end

  generate
    if (USE_RDY) begin : g_rdy
      logic [WW-1:0] wait_q;
      assign wait_ok = rdy_i || (wait_q == WW'(RDY_TMO));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                wait_q <= '0;
        else if (kick_i)                            wait_q <= '0;
        else if (active_q && min_ok && !wait_ok)    wait_q <= wait_q + WW'(1);
      end
    end else begin : g_fixed
      assign wait_ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/eerd_rx_capture.sv
module eerd_rx_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              last_i,
  input  logic              di_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] sh_q;
  logic              valid_q;

  // dummy leading zero falls off the top after the final shift
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= shift_i && last_i;
      if (shift_i) sh_q <= {sh_q[DATA_W-2:0], di_i};
    end
  end

  assign word_o  = sh_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
  import eerd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int T_HIGH  = 75,
  parameter int T_LOW   = 25,
  parameter bit USE_RDY = 1'b1,
  parameter int RDY_TMO = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W:0]   count_i,
  input  logic              rdy_i,
  input  logic              di_i,
  output logic              sk_o,
  output logic              cs_o,
  output logic              do_o,
  output logic [DATA_W-1:0] word_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int TX_W  = 3 + ADDR_W;

  eerd_state_e       state_q;
  logic              hi_q;
  logic [BC_W-1:0]   bitc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [TX_W-1:0]   tx_q;
  logic              done_q;

  logic idle, accept, accept_go, tmr_done, last_edge, kick, hi_next;
  logic rx_shift, rx_last;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = start_i && idle;
  assign accept_go = accept && (count_i != '0);
  assign last_edge = hi_q && (state_q == ST_CLOSE) && (left_q == CNT_W'(1));
  assign kick      = accept_go || (tmr_done && !last_edge);
  assign hi_next   = accept ? 1'b0 : !hi_q;
  assign rx_shift  = tmr_done && !hi_q && (state_q == ST_READ);
  assign rx_last   = (bitc_q == BC_W'(READ_BITS - 1));

  eerd_phase_timer #(
    .T_HIGH (T_HIGH),
    .T_LOW  (T_LOW),
    .USE_RDY(USE_RDY),
    .RDY_TMO(RDY_TMO)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(kick),
    .hi_i  (hi_next),
    .rdy_i (rdy_i),
    .done_o(tmr_done)
  );

  eerd_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(rx_shift),
    .last_i (rx_last),
    .di_i   (di_i),
    .word_o (word_o),
    .valid_o(valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hi_q    <= 1'b0;
      bitc_q  <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      tx_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (count_i == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_SEL;
          hi_q    <= 1'b0;
          bitc_q  <= '0;
          addr_q  <= start_addr_i;
          left_q  <= count_i;
        end
      end else if (tmr_done) begin
        if (!hi_q) begin
          hi_q <= 1'b1;
        end else begin
          hi_q   <= 1'b0;
          bitc_q <= bitc_q + BC_W'(1);
          unique case (state_q)
            ST_SEL: begin
              state_q <= ST_CMD;
              bitc_q  <= '0;
              tx_q    <= {CMD_READ, addr_q};
            end
            ST_CMD: begin
              tx_q <= tx_q << 1;
              if (bitc_q == BC_W'(2)) begin
                state_q <= ST_ADDR;
                bitc_q  <= '0;
              end
            end
            ST_ADDR: begin
              tx_q <= tx_q << 1;
              if (bitc_q == BC_W'(ADDR_W - 1)) begin
                state_q <= ST_READ;
                bitc_q  <= '0;
              end
            end
            ST_READ: begin
              if (rx_last) begin
                state_q <= ST_CLOSE;
                bitc_q  <= '0;
              end
            end
            ST_CLOSE: begin
              bitc_q <= '0;
              if (left_q == CNT_W'(1)) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= ST_SEL;
                addr_q  <= addr_q + ADDR_W'(1);
                left_q  <= left_q - CNT_W'(1);
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign sk_o   = hi_q && !idle;
  assign cs_o   = (state_q == ST_SEL) || (state_q == ST_CMD) ||
                  (state_q == ST_ADDR) || (state_q == ST_READ);
  assign do_o   = ((state_q == ST_CMD) || (state_q == ST_ADDR)) && tx_q[TX_W-1];
  assign addr_o = addr_q;
  assign busy_o = !idle;
  assign done_o = done_q;
endmodule

// File: rtl/eerd_checker.sv
module eerd_checker #(
  parameter int T_HIGH  = 75,
  parameter int T_LOW   = 25,
  parameter bit USE_RDY = 1'b1,
  parameter int RDY_TMO = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sk_o,
  input logic cs_o,
  input logic do_o,
  input logic valid_o,
  input logic busy_o,
  input logic done_o
);
  localparam int HI_MAX = T_HIGH + (USE_RDY ? RDY_TMO : 0);
  localparam int LO_MAX = T_LOW + (USE_RDY ? RDY_TMO : 0);

  logic [15:0] hi_run, lo_run, lo_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run  <= '0;
      lo_run  <= '0;
      lo_busy <= '0;
    end else begin
      hi_run  <= sk_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : 16'd0;
      lo_run  <= !sk_o ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1) : 16'd0;
      lo_busy <= (busy_o && !sk_o) ? ((lo_busy == 16'hFFFF) ? lo_busy : lo_busy + 16'd1) : 16'd0;
    end
  end

  a_r10_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sk_o) |-> hi_run >= 16'(T_HIGH));
  a_r10_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sk_o) |-> lo_run >= 16'(T_LOW));
  a_r11_high_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> hi_run < 16'(HI_MAX));
  a_r11_low_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sk_o) |-> lo_busy < 16'(LO_MAX));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sk_o && !cs_o && !do_o));
  a_r4_do_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> $stable(do_o));
  a_r3_open_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> !sk_o);
  a_r6_valid_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (busy_o && sk_o && cs_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind eeprom_burst_reader eerd_checker #(
  .T_HIGH (T_HIGH),
  .T_LOW  (T_LOW),
  .USE_RDY(USE_RDY),
  .RDY_TMO(RDY_TMO)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sk_o   (sk_o),
  .cs_o   (cs_o),
  .do_o   (do_o),
  .valid_o(valid_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/tb_eeprom_burst_reader.sv
module tb_eeprom_model #(
  parameter int AW = 6
) (
  input  logic sk,
  input  logic cs,
  input  logic din,
  output logic dout,
  output int   frames,
  output int   bad
);
  int pre, gap, n, k, bad_cs, bad_sk;
  logic started;
  logic [1:0] op;
  logic [AW-1:0] a;
  logic [15:0] w;

  function automatic logic [15:0] word_f(input int addr);
    logic [31:0] t;
    t = (addr * 40503) ^ (addr << 7) ^ 32'h3C5A;
    return t[15:0];
  endfunction

  initial begin
    dout = 0; frames = 0; pre = 0; gap = 0; n = 0; k = 0;
    bad_cs = 0; bad_sk = 0; started = 0; op = 0; a = 0; w = 0;
  end

  assign bad = bad_cs + bad_sk;

  always @(posedge cs) begin
    if (frames > 0 && gap != 1) bad_cs++;   // R7 one closing period
    frames++;
    gap = 0; pre = 0; n = 0; k = 0; started = 0;
  end

  always @(posedge sk) begin
    if (!cs) gap++;
    else if (!started) begin
      if (din) begin
        started = 1;
        if (pre != 1) bad_sk++;             // R3 one opening period
      end else pre++;
    end else if (n < 2) begin
      op = {op[0], din};
      n++;
      if (n == 2 && op != 2'b10) bad_sk++;  // R4 read opcode
    end else if (n < 2 + AW) begin
      a = {a[AW-2:0], din};
      n++;
      if (n == 2 + AW) dout = 1'b0;         // dummy zero
    end else if (k < 16) begin
      w = word_f(int'(a));
      dout = w[15-k];
      k++;
    end
  end
endmodule

module tb_eeprom_burst_reader;
  localparam int AW6 = 6, TH6 = 6, TL6 = 3, TMO6 = 8;
  localparam int AW8 = 8, TH8 = 4, TL8 = 2;
  localparam int P6 = AW6 + 22, P8 = AW8 + 22;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic           s6_start = 0, s6_rdy, s6_sk, s6_cs, s6_do, s6_di, s6_valid, s6_busy, s6_done;
  logic [AW6-1:0] s6_sa = 0, s6_addr;
  logic [AW6:0]   s6_cnt = 0;
  logic [15:0]    s6_word;
  logic           s8_start = 0, s8_sk, s8_cs, s8_do, s8_di, s8_valid, s8_busy, s8_done;
  logic [AW8-1:0] s8_sa = 0, s8_addr;
  logic [AW8:0]   s8_cnt = 0;
  logic [15:0]    s8_word;
  int m6_frames, m6_bad, m8_frames, m8_bad;

  eeprom_burst_reader #(.ADDR_W(AW6), .T_HIGH(TH6), .T_LOW(TL6), .USE_RDY(1'b1), .RDY_TMO(TMO6)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s6_start), .start_addr_i(s6_sa), .count_i(s6_cnt),
    .rdy_i(s6_rdy), .di_i(s6_di), .sk_o(s6_sk), .cs_o(s6_cs), .do_o(s6_do), .word_o(s6_word),
    .addr_o(s6_addr), .valid_o(s6_valid), .busy_o(s6_busy), .done_o(s6_done));

  eeprom_burst_reader #(.ADDR_W(AW8), .T_HIGH(TH8), .T_LOW(TL8), .USE_RDY(1'b0), .RDY_TMO(4)) dut_w8 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s8_start), .start_addr_i(s8_sa), .count_i(s8_cnt),
    .rdy_i(1'b0), .di_i(s8_di), .sk_o(s8_sk), .cs_o(s8_cs), .do_o(s8_do), .word_o(s8_word),
    .addr_o(s8_addr), .valid_o(s8_valid), .busy_o(s8_busy), .done_o(s8_done));

  tb_eeprom_model #(.AW(AW6)) m6 (.sk(s6_sk), .cs(s6_cs), .din(s6_do), .dout(s6_di), .frames(m6_frames), .bad(m6_bad));
  tb_eeprom_model #(.AW(AW8)) m8 (.sk(s8_sk), .cs(s8_cs), .din(s8_do), .dout(s8_di), .frames(m8_frames), .bad(m8_bad));

  // ready generator: 0 = always ready, 1 = stuck low, 2 = ready 4 cycles after each clock change
  int   rdy_mode = 0;
  int   since = 0;
  logic sk6_d = 0;
  always @(posedge clk) begin
    sk6_d <= s6_sk;
    if (s6_sk != sk6_d) since <= 0;
    else if (since < 255) since <= since + 1;
  end
  assign s6_rdy = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : (since >= 4);

  int n_chk = 0, n_bad = 0;
  int busy6 = 0, busy8 = 0, done6 = 0, done8 = 0;
  logic [31:0] q6[$];
  logic [31:0] q8[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (s6_busy) busy6++;
      if (s8_busy) busy8++;
      if (s6_done) done6++;
      if (s8_done) done8++;
      if (s6_valid) begin
        if (q6.size() == 0) check(0, "R6", "unexpected word (6b)", {8'(s6_addr), s6_word}, 0);
        else begin
          logic [31:0] e6;
          e6 = q6.pop_front();
          check({8'(s6_addr), s6_word} == e6, "R5/R8", "word+addr (6b)", {8'(s6_addr), s6_word}, e6);
        end
      end
      if (s8_valid) begin
        if (q8.size() == 0) check(0, "R6", "unexpected word (8b)", {8'(s8_addr), s8_word}, 0);
        else begin
          logic [31:0] e8;
          e8 = q8.pop_front();
          check({8'(s8_addr), s8_word} == e8, "R5/R8", "word+addr (8b)", {8'(s8_addr), s8_word}, e8);
        end
      end
    end
  end

  task automatic run6(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      int aa;
      aa = (a + i) % 64;
      q6.push_back({8'(aa), m6.word_f(aa)});
    end
    busy6 = 0; done6 = 0;
    @(negedge clk);
    s6_start = 1; s6_sa = AW6'(a); s6_cnt = (AW6+1)'(n);
    @(negedge clk);
    s6_start = 0;
  endtask

  task automatic run8(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      int aa;
      aa = (a + i) % 256;
      q8.push_back({8'(aa), m8.word_f(aa)});
    end
    busy8 = 0; done8 = 0;
    @(negedge clk);
    s8_start = 1; s8_sa = AW8'(a); s8_cnt = (AW8+1)'(n);
    @(negedge clk);
    s8_start = 0;
  endtask

  task automatic wait6;
    while (done6 == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait8;
    while (done8 == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check({s6_busy, s6_valid, s6_done, s6_sk, s6_cs, s6_do} == 6'b0, "R12", "reset outputs 6b",
          {s6_busy, s6_valid, s6_done, s6_sk, s6_cs, s6_do}, 0);
    check({s8_busy, s8_valid, s8_done, s8_sk, s8_cs, s8_do} == 6'b0, "R12", "reset outputs 8b",
          {s8_busy, s8_valid, s8_done, s8_sk, s8_cs, s8_do}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 busy rises the cycle after start; R10 exact run length
    run6(5, 3);
    check(s6_busy == 1'b1, "R1", "busy after start", s6_busy, 1);
    wait6();
    check(busy6 == 3 * P6 * (TL6 + TH6), "R10", "busy cycles 3 words", busy6, 3 * P6 * (TL6 + TH6));
    check(done6 == 1, "R9", "one done pulse", done6, 1);
    check(q6.size() == 0, "R6", "all words delivered", q6.size(), 0);
    check({s6_sk, s6_cs, s6_do} == 3'b0, "R7", "bus quiet after run", {s6_sk, s6_cs, s6_do}, 0);
    check(m6_bad == 0, "R3/R4/R7", "frame shape seen by memory", m6_bad, 0);
    check(m6_frames == 3, "R8", "frame count", m6_frames, 3);

    // R8 address wrap
    run6(62, 4);
    wait6();
    check(q6.size() == 0, "R8", "wrapped words delivered", q6.size(), 0);

    // R2 zero count
    busy6 = 0; done6 = 0;
    @(negedge clk);
    s6_start = 1; s6_sa = 6'd9; s6_cnt = '0;
    @(negedge clk);
    s6_start = 0;
    check(s6_done == 1'b1 && s6_busy == 1'b0, "R2", "immediate done, busy low", {s6_done, s6_busy}, 2'b10);
    @(negedge clk);
    check(s6_done == 1'b0, "R2", "done is one pulse", s6_done, 0);
    repeat (20) @(negedge clk);
    check(busy6 == 0 && m6_frames == 7, "R2", "no frame for zero count", m6_frames, 7);

    // R1 start while busy ignored
    run6(10, 2);
    repeat (100) @(negedge clk);
    s6_start = 1; s6_sa = 6'd40; s6_cnt = 7'd5;
    @(negedge clk);
    s6_start = 0;
    wait6();
    check(done6 == 1, "R1", "single done despite second start", done6, 1);
    check(busy6 == 2 * P6 * (TL6 + TH6), "R1", "run length unchanged", busy6, 2 * P6 * (TL6 + TH6));
    repeat (30) @(negedge clk);
    check(s6_busy == 1'b0 && q6.size() == 0, "R1", "no extra words", q6.size(), 0);

    // R11 ready stuck low: every phase runs to timeout
    rdy_mode = 1;
    run6(20, 1);
    wait6();
    check(busy6 == P6 * (TL6 + TH6 + 2 * TMO6), "R11", "timeout run length", busy6, P6 * (TL6 + TH6 + 2 * TMO6));
    check(q6.size() == 0, "R11", "word read under timeout", q6.size(), 0);

    // R11 delayed ready: phases stretched, data intact
    rdy_mode = 2;
    run6(33, 2);
    wait6();
    check(busy6 > 2 * P6 * (TL6 + TH6), "R11", "ready stretches phases", busy6, 2 * P6 * (TL6 + TH6));
    check(q6.size() == 0 && m6_bad == 0, "R11", "words under handshake", m6_bad, 0);
    rdy_mode = 0;

    // 8-bit address variant, no handshake
    run8(200, 3);
    wait8();
    check(busy8 == 3 * P8 * (TL8 + TH8), "R10", "busy cycles 8b", busy8, 3 * P8 * (TL8 + TH8));
    run8(255, 2);
    wait8();
    check(q8.size() == 0, "R8", "8b wrap words delivered", q8.size(), 0);
    check(m8_bad == 0 && m8_frames == 5, "R4", "8b frame shape", m8_bad, 0);

    summary();
    $finish;
  end
endmodule